// File: doc/BRIEF.md
# Category-Priority LRU Victim Selector

This block picks the way to replace in one 8-way set of a cache bank whose lines are each tagged with the path by which the data arrived. Four origins are tracked: a fetch from off-chip memory, a write-back caused by an L1 eviction, an upward migration (promotion) and a downward migration (demotion). The block keeps a full recency order of the set, a valid bit per way and the origin tag of each way.

When the set is full, the victim is not simply the least-recent way. The two oldest ways are compared, and the one whose origin ranks lower is chosen. Only those two ways are compared, so a high-ranking origin cannot take over the whole set. The ranking is fixed, but a different table applies depending on whether the bank is configured as a near (local) bank or a shared central bank. While any way is still empty, the lowest-numbered empty way is used and no ranking takes place.

The victim outputs are combinational from the state held at the start of the cycle. A fill writes its origin tag into the victim way, marks it valid and moves it to the most-recent position. A hit moves a valid way to the most-recent position and leaves its tag unchanged.

Top module: `prio_lru_victim_sel`

## Requirements
- R1: Synchronous active-high reset clears all valid bits and all origin tags to code 0. It sets the recency order so that position p holds way p, where position 0 is the most recent and position 7 the least recent. The `recency` port carries position p in bits [3p+2:3p]. While the set is empty, `victim_way` reads 0 with category 0.
- R2: Origin codes are 0 off-chip, 1 L1 write-back, 2 promoted and 3 demoted. `victim_level` gives the priority level, where 0 is the highest (P1) and 3 the lowest (P4). With `bank_central` = 0 the levels are L1 write-back 0, promoted 1, off-chip 2 and demoted 3.
- R3: With `bank_central` = 1 the levels are promoted 0, off-chip 1, demoted 2 and L1 write-back 3.
- R4: While any way is invalid, the victim is the lowest-numbered invalid way, whatever the origin tags are. `victim_cat` and `victim_level` then report that way's stored tag.
- R5: When all ways are valid, only the ways at positions 7 and 6 are compared. The victim is the one with the larger level number. `victim_cat` and `victim_level` report the victim's tag and level.
- R6: When the two compared ways have equal levels, the way at position 7 is the victim.
- R7: A fill writes `fill_cat` into the victim way and sets its valid bit. The victim way moves to position 0, and every way that was more recent than it moves one position older. The result is visible after the clock edge.
- R8: A hit on a valid way moves that way to position 0 in the same manner. Its origin tag and all valid bits are left unchanged.
- R9: A hit on an invalid way is ignored. The recency order and the valid bits stay unchanged.
- R10: When a hit and a fill occur in the same cycle, the victim is taken from the state before that cycle. The hit is applied first and the fill second, so the filled way ends at position 0 and the hit way at position 1. If the hit way is the victim, the way ends at position 0 carrying the new tag.
- R11: `bank_central` acts combinationally on the victim outputs in the same cycle and does not change any stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_central | input | 1 | 1 selects the central-bank ranking, 0 the local-bank ranking |
| hit_valid | input | 1 | Lookup hit update this cycle |
| hit_way | input | 3 | Way that hit |
| fill_valid | input | 1 | Fill into the current victim way this cycle |
| fill_cat | input | 2 | Origin code of the filled line |
| victim_way | output | 3 | Way a fill would replace now |
| victim_cat | output | 2 | Origin code stored in the victim way |
| victim_level | output | 2 | Priority level of the victim (0 = P1 ... 3 = P4) |
| way_valid | output | 8 | Valid bit per way |
| recency | output | 24 | Recency order, 3 bits per position, position 0 most recent |

## Verification
A hit and a fill can land in the same cycle, and the block must then apply both reorderings in a fixed order against a victim chosen from the old state. The bench provokes this case in two ways. In one, a hit goes to a different way while a fill replaces the victim. In the other, the hit goes to the very way being replaced. Random traffic supplies further overlaps. Each overlap is judged by comparing the recency vector, the valid mask and the next victim's reported origin against a reference model that applies the hit and then the fill.

// File: rtl/prio_lru_pkg.sv
package prio_lru_pkg;

    localparam int NUM_CATS = 4;
    localparam int CAT_W    = 2;
    localparam int LVL_W    = 2;
    localparam int TBL_W    = NUM_CATS * LVL_W;

    typedef enum logic [CAT_W-1:0] {
        CAT_OFFCHIP = 2'd0,
        CAT_L1WB    = 2'd1,
        CAT_PROMO   = 2'd2,
        CAT_DEMO    = 2'd3
    } cat_e;

    typedef logic [LVL_W-1:0] level_t;

    typedef struct packed {
        cat_e   cat;
        level_t level;
    } cand_t;

    // Level of category c sits at bits [2c+1:2c]; 0 = highest priority.
    // local : L1WB=0 PROMO=1 OFFCHIP=2 DEMO=3
    localparam logic [TBL_W-1:0] RANK_LOCAL_DEF   = 8'hD2;
    // central: PROMO=0 OFFCHIP=1 DEMO=2 L1WB=3
    localparam logic [TBL_W-1:0] RANK_CENTRAL_DEF = 8'h8D;

    function automatic level_t level_of(input logic [TBL_W-1:0] tbl, input cat_e c);
        return tbl[int'(c) * LVL_W +: LVL_W];
    endfunction

endpackage

// File: rtl/prio_lru_recency.sv
module prio_lru_recency #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hit_en,
    input  logic [WAY_W-1:0]        hit_way,
    input  logic                    fill_en,
    input  logic [WAY_W-1:0]        fill_way,
    output logic [WAYS*WAY_W-1:0]   order,
    output logic [WAYS-1:0]         valid
);
    localparam int ORD_W = WAYS * WAY_W;

    logic [ORD_W-1:0] ord_q, ord_hit, ord_next;
    logic [WAYS-1:0]  val_q;
    logic [WAYS-1:0]  present;

    // Move way w to position 0, shifting the more recent ways down by one.
    function automatic logic [ORD_W-1:0] promote(input logic [ORD_W-1:0] o,
                                                 input logic [WAY_W-1:0] w);
        logic [ORD_W-1:0] r;
        logic [WAY_W-1:0] carry;
        logic             done;
        r     = o;
        carry = w;
        done  = 1'b0;
        for (int p = 0; p < WAYS; p++) begin
            if (!done) begin
                r[p*WAY_W +: WAY_W] = carry;
                if (o[p*WAY_W +: WAY_W] == w) done = 1'b1;
                else carry = o[p*WAY_W +: WAY_W];
            end
        end
        return r;
    endfunction

    always_comb begin
        ord_hit  = hit_en  ? promote(ord_q, hit_way)    : ord_q;
        ord_next = fill_en ? promote(ord_hit, fill_way) : ord_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < WAYS; p++) ord_q[p*WAY_W +: WAY_W] <= WAY_W'(p);
            val_q <= '0;
        end else begin
            ord_q <= ord_next;
            if (fill_en) val_q[fill_way] <= 1'b1;
        end
    end

    assign order = ord_q;
    assign valid = val_q;

    always_comb begin
        present = '0;
        for (int p = 0; p < WAYS; p++) present[ord_q[p*WAY_W +: WAY_W]] = 1'b1;
    end

    // R7: the recency order stays a permutation of all ways
    p_order_perm_r7: assert property (@(posedge clk) disable iff (rst) &present);

    // R7: valid bits never clear outside reset
    p_valid_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((val_q & $past(val_q)) == $past(val_q)));

endmodule

// File: rtl/prio_lru_cat_store.sv
module prio_lru_cat_store
    import prio_lru_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [WAY_W-1:0]      wway,
    input  cat_e                  wcat,
    output logic [WAYS*CAT_W-1:0] cats
);
    logic [WAYS*CAT_W-1:0] cat_q;

    always_ff @(posedge clk) begin
        if (rst) cat_q <= '0;
        else if (we) cat_q[wway*CAT_W +: CAT_W] <= wcat;
    end

    assign cats = cat_q;

    // R8: without a fill, no origin tag changes (a hit keeps its tag)
    p_cat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cat_q));

    // R7: a fill leaves the written tag in its way
    p_cat_write_r7: assert property (@(posedge clk) disable iff (rst)
        we |=> cat_q[$past(wway)*CAT_W +: CAT_W] == $past(wcat));

endmodule

// File: rtl/prio_lru_pick.sv
module prio_lru_pick
    import prio_lru_pkg::*;
#(
    parameter int                WAYS         = 8,
    parameter int                WAY_W        = $clog2(WAYS),
    parameter logic [TBL_W-1:0]  RANK_LOCAL   = RANK_LOCAL_DEF,
    parameter logic [TBL_W-1:0]  RANK_CENTRAL = RANK_CENTRAL_DEF
) (
    input  logic [WAYS*WAY_W-1:0] order,
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS*CAT_W-1:0] cats,
    input  logic                  central,
    output logic [WAY_W-1:0]      way,
    output cand_t                 pick
);
    localparam int LRU_POS = WAYS - 1;
    localparam int NXT_POS = WAYS - 2;

    logic [TBL_W-1:0] tbl;
    logic             inv_found;
    logic [WAY_W-1:0] inv_way, lru_way, nxt_way, sel;
    cat_e             lru_c, nxt_c, sel_c;
    level_t           lru_l, nxt_l;

    always_comb begin
        tbl       = central ? RANK_CENTRAL : RANK_LOCAL;
        inv_found = 1'b0;
        inv_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
        end
        lru_way = order[LRU_POS*WAY_W +: WAY_W];
        nxt_way = order[NXT_POS*WAY_W +: WAY_W];
        lru_c   = cat_e'(cats[lru_way*CAT_W +: CAT_W]);
        nxt_c   = cat_e'(cats[nxt_way*CAT_W +: CAT_W]);
        lru_l   = level_of(tbl, lru_c);
        nxt_l   = level_of(tbl, nxt_c);
        if (inv_found)          sel = inv_way;
        else if (nxt_l > lru_l) sel = nxt_way;
        else                    sel = lru_way;
        sel_c      = cat_e'(cats[sel*CAT_W +: CAT_W]);
        way        = sel;
        pick.cat   = sel_c;
        pick.level = level_of(tbl, sel_c);
    end

endmodule

// File: rtl/prio_lru_victim_sel.sv
module prio_lru_victim_sel
    import prio_lru_pkg::*;
#(
    parameter int               WAYS         = 8,
    parameter logic [TBL_W-1:0] RANK_LOCAL   = RANK_LOCAL_DEF,
    parameter logic [TBL_W-1:0] RANK_CENTRAL = RANK_CENTRAL_DEF,
    localparam int              WAY_W        = $clog2(WAYS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bank_central,
    input  logic                   hit_valid,
    input  logic [WAY_W-1:0]       hit_way,
    input  logic                   fill_valid,
    input  logic [CAT_W-1:0]       fill_cat,
    output logic [WAY_W-1:0]       victim_way,
    output logic [CAT_W-1:0]       victim_cat,
    output logic [LVL_W-1:0]       victim_level,
    output logic [WAYS-1:0]        way_valid,
    output logic [WAYS*WAY_W-1:0]  recency
);
    logic [WAYS*WAY_W-1:0] order_w;
    logic [WAYS-1:0]       valid_w;
    logic [WAYS*CAT_W-1:0] cats_w;
    logic [WAY_W-1:0]      vway;
    cand_t                 vpick;
    logic                  hit_en;

    assign hit_en = hit_valid && valid_w[hit_way];

    prio_lru_recency #(.WAYS(WAYS), .WAY_W(WAY_W)) u_rec (
        .clk(clk), .rst(rst),
        .hit_en(hit_en), .hit_way(hit_way),
        .fill_en(fill_valid), .fill_way(vway),
        .order(order_w), .valid(valid_w)
    );

    prio_lru_cat_store #(.WAYS(WAYS), .WAY_W(WAY_W)) u_cat (
        .clk(clk), .rst(rst),
        .we(fill_valid), .wway(vway), .wcat(cat_e'(fill_cat)),
        .cats(cats_w)
    );

    prio_lru_pick #(
        .WAYS(WAYS), .WAY_W(WAY_W),
        .RANK_LOCAL(RANK_LOCAL), .RANK_CENTRAL(RANK_CENTRAL)
    ) u_pick (
        .order(order_w), .valid(valid_w), .cats(cats_w),
        .central(bank_central), .way(vway), .pick(vpick)
    );

    assign victim_way   = vway;
    assign victim_cat   = vpick.cat;
    assign victim_level = vpick.level;
    assign way_valid    = valid_w;
    assign recency      = order_w;

    // R4: while a way is empty, an empty way is chosen
    p_invalid_first_r4: assert property (@(posedge clk) disable iff (rst)
        !(&valid_w) |-> !valid_w[vway]);

    // R5: a full set evicts one of the two oldest ways
    p_candidate_r5: assert property (@(posedge clk) disable iff (rst)
        (&valid_w) |-> (vway == order_w[(WAYS-1)*WAY_W +: WAY_W] ||
                        vway == order_w[(WAYS-2)*WAY_W +: WAY_W]));

    // R7: the filled way becomes most recent and valid
    p_fill_mru_r7: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> (order_w[WAY_W-1:0] == $past(vway)) && valid_w[$past(vway)]);

    // R8: a lone hit on a valid way becomes most recent, valid mask unchanged
    p_hit_mru_r8: assert property (@(posedge clk) disable iff (rst)
        (hit_en && !fill_valid) |=> (order_w[WAY_W-1:0] == $past(hit_way)) && $stable(valid_w));

    // R9: a hit on an invalid way changes nothing
    p_hit_invalid_r9: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && !valid_w[hit_way] && !fill_valid) |=> $stable(order_w) && $stable(valid_w));

    // R10: hit then fill in one cycle leaves the hit way second most recent
    p_hit_fill_r10: assert property (@(posedge clk) disable iff (rst)
        (hit_en && fill_valid && hit_way != vway) |=> order_w[WAY_W +: WAY_W] == $past(hit_way));

endmodule

// File: tb/prio_lru_victim_sel_test.sv
`timescale 1ns/100ps
module prio_lru_victim_sel_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        bank_central, hit_valid, fill_valid;
    logic [2:0]  hit_way;
    logic [1:0]  fill_cat;
    logic [2:0]  victim_way;
    logic [1:0]  victim_cat, victim_level;
    logic [7:0]  way_valid;
    logic [23:0] recency;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int m_ord[8];
    bit m_val[8];
    int m_cat[8];

    always #2.5 clk = ~clk;

    prio_lru_victim_sel uut (
        .clk(clk), .rst(rst), .bank_central(bank_central),
        .hit_valid(hit_valid), .hit_way(hit_way),
        .fill_valid(fill_valid), .fill_cat(fill_cat),
        .victim_way(victim_way), .victim_cat(victim_cat), .victim_level(victim_level),
        .way_valid(way_valid), .recency(recency)
    );

    // Fill sequence from reset: category per row, expected victim and level (local bank)
    typedef struct packed {
        logic [1:0] cat;
        logic [2:0] exp_way;
        logic [1:0] exp_lvl;
    } vec_t;
    localparam vec_t VEC[8] = '{
        '{2'd2, 3'd0, 2'd2}, '{2'd0, 3'd1, 2'd2}, '{2'd1, 3'd2, 2'd2}, '{2'd3, 3'd3, 2'd2},
        '{2'd0, 3'd4, 2'd2}, '{2'd2, 3'd5, 2'd2}, '{2'd1, 3'd6, 2'd2}, '{2'd3, 3'd7, 2'd2}
    };

    function automatic int lvl(input int c, input bit cen);
        if (!cen) begin
            case (c) 0: return 2; 1: return 0; 2: return 1; default: return 3; endcase
        end else begin
            case (c) 0: return 1; 1: return 3; 2: return 0; default: return 2; endcase
        end
    endfunction

    function automatic int exp_victim(input bit cen);
        for (int w = 0; w < 8; w++) if (!m_val[w]) return w;
        if (lvl(m_cat[m_ord[6]], cen) > lvl(m_cat[m_ord[7]], cen)) return m_ord[6];
        return m_ord[7];
    endfunction

    function automatic string vtag(input bit cen);
        for (int w = 0; w < 8; w++) if (!m_val[w]) return "R4";
        if (lvl(m_cat[m_ord[6]], cen) == lvl(m_cat[m_ord[7]], cen)) return "R6";
        return cen ? "R3" : "R5";
    endfunction

    function automatic int model_flat();
        logic [23:0] f;
        for (int p = 0; p < 8; p++) f[p*3 +: 3] = 3'(m_ord[p]);
        return int'(f);
    endfunction

    function automatic int model_valid();
        logic [7:0] v;
        for (int w = 0; w < 8; w++) v[w] = m_val[w];
        return int'(v);
    endfunction

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < 8; p++) begin
            m_ord[p] = p;
            m_val[p] = 1'b0;
            m_cat[p] = 0;
        end
    endtask

    task automatic model_promote(input int w);
        int k = 0;
        for (int p = 0; p < 8; p++) if (m_ord[p] == w) k = p;
        for (int p = k; p > 0; p--) m_ord[p] = m_ord[p-1];
        m_ord[0] = w;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; hit_valid = 1'b0; fill_valid = 1'b0; bank_central = 1'b0;
        hit_way = '0; fill_cat = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        chk("R1", "way_valid after reset", int'(way_valid), 0);
        chk("R1", "recency after reset", int'(recency), model_flat());
        chk("R1", "victim_way after reset", int'(victim_way), 0);
        chk("R1", "victim_cat after reset", int'(victim_cat), 0);
    endtask

    // One cycle: exp_way / exp_lvl < 0 means "model only"
    task automatic step(input bit hv, input int hw, input bit fv, input int fc,
                        input bit cen, input int exp_way, input int exp_lvl);
        int    v;
        string tag;
        @(negedge clk);
        hit_valid = hv; hit_way = 3'(hw); fill_valid = fv; fill_cat = 2'(fc); bank_central = cen;
        #1;
        v = exp_victim(cen);
        if (exp_way >= 0) chk(vtag(cen), "victim_way (table)", int'(victim_way), exp_way);
        if (exp_lvl >= 0) chk(cen ? "R3" : "R2", "victim_level (table)", int'(victim_level), exp_lvl);
        chk(vtag(cen), "victim_way", int'(victim_way), v);
        chk(vtag(cen), "victim_cat", int'(victim_cat), m_cat[v]);
        chk(cen ? "R3" : "R2", "victim_level", int'(victim_level), lvl(m_cat[v], cen));
        @(posedge clk);
        #1;
        if (hv && fv)        tag = "R10";
        else if (fv)         tag = "R7";
        else if (hv && m_val[hw]) tag = "R8";
        else if (hv)         tag = "R9";
        else                 tag = "R11";
        if (hv && m_val[hw]) model_promote(hw);
        if (fv) begin
            m_cat[v] = fc;
            m_val[v] = 1'b1;
            model_promote(v);
        end
        chk(tag, "recency", int'(recency), model_flat());
        chk(tag, "way_valid", int'(way_valid), model_valid());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1;
        do_reset();

        // R4 / R7: fill an empty set row by row from the table
        for (int i = 0; i < 8; i++)
            step(1'b0, 0, 1'b1, int'(VEC[i].cat), 1'b0, int'(VEC[i].exp_way), int'(VEC[i].exp_lvl));

        // R5: oldest is promoted, next is off-chip -> off-chip (way 1) goes
        step(1'b0, 0, 1'b0, 0, 1'b0, 1, 2);
        // R11 / R3: same state, central ranking, same cycle
        step(1'b0, 0, 1'b0, 0, 1'b1, 1, 1);
        // R8: hit way 1; then central picks L1 write-back way 2 over promoted way 0
        step(1'b1, 1, 1'b0, 0, 1'b0, -1, -1);
        step(1'b0, 0, 1'b0, 0, 1'b1, 2, 3);
        // R6: bring two promoted lines to the bottom -> tie, oldest (way 0) goes
        step(1'b1, 2, 1'b0, 0, 1'b0, -1, -1);
        step(1'b1, 3, 1'b0, 0, 1'b0, -1, -1);
        step(1'b1, 4, 1'b0, 0, 1'b0, -1, -1);
        step(1'b0, 0, 1'b0, 0, 1'b0, 0, 1);
        // R10: hit on another way plus fill in the same cycle
        step(1'b1, 5, 1'b1, 3, 1'b0, 0, -1);
        // R10: hit on the victim way itself plus fill
        step(1'b1, 7, 1'b1, 1, 1'b0, 7, -1);
        step(1'b0, 0, 1'b0, 0, 1'b0, -1, -1);

        // R9: hit on an invalid way after reset
        do_reset();
        step(1'b1, 3, 1'b0, 0, 1'b0, -1, -1);
        step(1'b1, 0, 1'b0, 0, 1'b1, -1, -1);

        // Mixed traffic against the model
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            if (n == 300) do_reset();
            step(lfsr[0], int'(lfsr[3:1]), lfsr[5:4] == 2'b00 || lfsr[6],
                 int'(lfsr[8:7]), lfsr[9], -1, -1);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end

        summary();
    end

endmodule